// File: doc/BRIEF.md
# Serial Command Port with Latched Interrupt

This block is the microcontroller-facing control port of a message record and playback engine. A host writes one 24-bit command per select window over a four-wire SPI bus in mode 0: an 8-bit control byte first, then a 16-bit start address, most significant bit first. While the host shifts the command in, the block shifts status back out: the two event flags and the sequencer's current address. One frame therefore both reads the pending status and issues the next operation.

All SPI pins are brought into the system clock domain through synchronizer flops, and edges are found there. A command takes effect only when select is released, and only if exactly 24 rising SCLK edges were counted in that window. The block then latches the decoded control fields and the address, and emits a one-cycle go strobe toward the sequencer. It also keeps the operation-active bit, which the sequencer clears with a done pulse. Overflow and end-of-message events from the sequencer are held in two flags. These flags drive an open-drain, active-low interrupt. The flags stay set until the next select window opens. Nothing at the edge of this block is a data stream, so every pin is a plain level or pulse. No valid/ready handshake applies and there is no back-pressure. The host paces every transfer with SCLK.

Top module: `spi_cmd_port`

## Requirements
- R1: `miso_oe` is high only while select is held low; after select rises it returns low. When `miso_oe` is low the MISO pin is to be left undriven.
- R2: MOSI is sampled on rising SCLK edges. The first 8 bits form the control byte and the next 16 form the address, both sent most significant bit first.
- R3: The bits on MISO change on falling SCLK edges. Their order is: the overflow flag, then the end-of-message flag, then the 16 address bits from `seq_addr`, most significant bit first, then six zeros. The snapshot is taken when select falls.
- R4: `cmd_go` pulses high for exactly one system cycle after select rises, provided exactly 24 rising SCLK edges were counted in that window.
- R5: A window with fewer or more than 24 rising SCLK edges is dropped. No `cmd_go` pulse follows, and every command output keeps its value.
- R6: The control byte decodes as follows. Bit 7 is `cmd_cue`, bit 6 is `cmd_record` (1 = record, 0 = play), bit 5 is `cmd_run` and bit 4 is `cmd_use_addr`. Bits 3..0 appear on `cmd_aux`.
- R7: A pulse on `seq_ovf_evt` or `seq_eom_evt` sets the matching flag one cycle later. `irq_pull` (active: pin pulled low) then stays high until it is cleared.
- R8: Both flags clear when select falls. An event in that same cycle wins, and its flag stays set.
- R9: `op_run` is set by an accepted command whose run bit is 1. It is cleared by an accepted command whose run bit is 0, or by a `seq_done` pulse. An accepted command wins over `seq_done` in the same cycle.
- R10: The command outputs change only together with a `cmd_go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Serial command data from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial status data to the host |
| miso_oe | output | 1 | Output enable for the MISO pad |
| irq_pull | output | 1 | Open-drain control: 1 pulls the interrupt pin low |
| seq_addr | input | 16 | Current address of the sequencer, reported as status |
| seq_ovf_evt | input | 1 | One-cycle pulse: end of storage reached |
| seq_eom_evt | input | 1 | One-cycle pulse: end-of-message marker found |
| seq_done | input | 1 | One-cycle pulse: the running operation finished |
| cmd_go | output | 1 | One-cycle strobe: a new command is latched |
| cmd_cue | output | 1 | Decoded message-skip request |
| cmd_record | output | 1 | Decoded direction: 1 record, 0 play |
| cmd_run | output | 1 | Decoded run request bit |
| cmd_use_addr | output | 1 | Decoded: start at `cmd_addr` |
| cmd_aux | output | 4 | Low control-byte bits, passed through |
| cmd_addr | output | 16 | Latched start address |
| op_run | output | 1 | Operation-active bit |

## Verification
The bench sends frames of 20, 24 and 25 clocks. A design that counts loosely would launch a command from a truncated or overlong window, and the unexpected `cmd_go` or a change on `cmd_addr` would show it. Events are raised between windows and also in the middle of a window. A design that clears the flags at the wrong moment would lose an event or report it a frame early, and the interrupt level checked in the next frame would show the error. Status words use distinct address patterns, so a reversed bit order or an off-by-one shift timing corrupts the captured word. The run bit is driven through set, clear-by-command and clear-by-done sequences.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CTRL_W = 8;
  localparam int ADDR_W = 16;
  localparam int FRAME_W = CTRL_W + ADDR_W;
  localparam int STAT_W = 2 + ADDR_W;
  localparam int PAD_W = FRAME_W - STAT_W;

  typedef struct packed {
    logic       cue;
    logic       record;
    logic       run;
    logic       use_addr;
    logic [3:0] aux;
  } ctrl_t;
endpackage

// File: rtl/spi_sync_vec.sv
module spi_sync_vec #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_VAL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FRAME_W = 24,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               cs_active,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] status_word,
  output logic               miso_bit,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] rx_word,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      tx_q  <= status_word;
    end else if (cs_active) begin
      if (sclk_rise) begin
        rx_q <= {rx_q[FRAME_W-2:0], mosi};
        if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso_bit = tx_q[FRAME_W-1];
  assign frame_ok = cs_rise && (cnt_q == FULL);
  assign rx_word  = rx_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/spi_irq_hold.sv
module spi_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovf,
  input  logic set_eom,
  input  logic clr,
  output logic ovf,
  output logic eom
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      eom <= 1'b0;
    end else begin
      ovf <= set_ovf | (ovf & ~clr);
      eom <= set_eom | (eom & ~clr);
    end
  end
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              miso_oe,
  output logic              irq_pull,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic              seq_ovf_evt,
  input  logic              seq_eom_evt,
  input  logic              seq_done,
  output logic              cmd_go,
  output logic              cmd_cue,
  output logic              cmd_record,
  output logic              cmd_run,
  output logic              cmd_use_addr,
  output logic [3:0]        cmd_aux,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              op_run
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [2:0] pins_s;
  logic cs_s, sclk_s, mosi_s;
  logic cs_prev, sclk_prev;
  logic cs_fall, cs_rise, cs_active, sclk_rise, sclk_fall;
  logic flag_ovf, flag_eom;
  logic frame_ok;
  logic [FRAME_W-1:0] rx_word, status_word;
  logic [CNT_W-1:0] bit_cnt;
  ctrl_t ctrl_q, ctrl_new;
  logic [ADDR_W-1:0] addr_q;
  logic go_q, run_q;

  spi_sync_vec #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end

  assign cs_fall   = cs_prev & ~cs_s;
  assign cs_rise   = ~cs_prev & cs_s;
  assign cs_active = ~cs_s;
  assign sclk_rise = ~sclk_prev & sclk_s;
  assign sclk_fall = sclk_prev & ~sclk_s;

  spi_irq_hold u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_ovf(seq_ovf_evt), .set_eom(seq_eom_evt), .clr(cs_fall),
    .ovf(flag_ovf), .eom(flag_eom)
  );

  assign status_word = {flag_ovf, flag_eom, seq_addr, {PAD_W{1'b0}}};

  spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_active(cs_active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
    .status_word(status_word),
    .miso_bit(spi_miso), .frame_ok(frame_ok),
    .rx_word(rx_word), .bit_cnt(bit_cnt)
  );

  assign ctrl_new = ctrl_t'(rx_word[FRAME_W-1 -: CTRL_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      go_q   <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      go_q <= frame_ok;
      if (frame_ok) begin
        ctrl_q <= ctrl_new;
        addr_q <= rx_word[ADDR_W-1:0];
        run_q  <= ctrl_new.run;
      end else if (seq_done) begin
        run_q <= 1'b0;
      end
    end
  end

  assign miso_oe      = cs_active;
  assign irq_pull     = flag_ovf | flag_eom;
  assign cmd_go       = go_q;
  assign cmd_cue      = ctrl_q.cue;
  assign cmd_record   = ctrl_q.record;
  assign cmd_run      = ctrl_q.run;
  assign cmd_use_addr = ctrl_q.use_addr;
  assign cmd_aux      = ctrl_q.aux;
  assign cmd_addr     = addr_q;
  assign op_run       = run_q;
endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk #(
  parameter int FRAME_W = 24,
  parameter int CNT_W = 5,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              frame_ok,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              cmd_go,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              irq_pull,
  input logic              seq_ovf_evt,
  input logic              seq_eom_evt,
  input logic              seq_done,
  input logic              op_run,
  input logic              miso_oe
);
  assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);
  assert_go_full_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> ($past(cs_rise) && $past(bit_cnt) == CNT_W'(FRAME_W)));
  assert_short_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CNT_W'(FRAME_W)) |=> !cmd_go);
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(cmd_addr));
  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ovf_evt || seq_eom_evt) |=> irq_pull);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull && !cs_fall) |=> irq_pull);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !seq_ovf_evt && !seq_eom_evt) |=> !irq_pull);
  assert_run_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !frame_ok) |=> !op_run);
  assert_oe_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> !miso_oe);
endmodule

bind spi_cmd_port spi_cmd_port_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .frame_ok(frame_ok), .bit_cnt(bit_cnt), .cmd_go(cmd_go), .cmd_addr(cmd_addr),
  .irq_pull(irq_pull), .seq_ovf_evt(seq_ovf_evt), .seq_eom_evt(seq_eom_evt),
  .seq_done(seq_done), .op_run(op_run), .miso_oe(miso_oe)
);

// File: tb/test_spi_cmd_port.sv
module test_spi_cmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso, miso_oe, irq_pull;
  logic [15:0] seq_addr = 16'hA5C3;
  logic seq_ovf_evt = 1'b0, seq_eom_evt = 1'b0, seq_done = 1'b0;
  logic cmd_go, cmd_cue, cmd_record, cmd_run, cmd_use_addr, op_run;
  logic [3:0] cmd_aux;
  logic [15:0] cmd_addr;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  spi_cmd_port i_spi_cmd_port (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .miso_oe(miso_oe),
    .irq_pull(irq_pull), .seq_addr(seq_addr), .seq_ovf_evt(seq_ovf_evt),
    .seq_eom_evt(seq_eom_evt), .seq_done(seq_done), .cmd_go(cmd_go),
    .cmd_cue(cmd_cue), .cmd_record(cmd_record), .cmd_run(cmd_run),
    .cmd_use_addr(cmd_use_addr), .cmd_aux(cmd_aux), .cmd_addr(cmd_addr),
    .op_run(op_run)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: runs one select window with nbits clocks; a full frame is pushed to the scoreboard.
  task automatic frame(input logic [23:0] cmd, input int nbits, input logic [23:0] exp_stat);
    logic [23:0] got = '0;
    spi_cs_n = 1'b0;
    wait_n(10);
    check(miso_oe == 1'b1, "R1 oe while selected", 32'(miso_oe), 1);
    check(irq_pull == 1'b0, "R8 irq cleared at select", 32'(irq_pull), 0);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 24) ? cmd[23-i] : 1'b0;
      wait_n(10);
      if (i < 24) got[23-i] = spi_miso;
      spi_sclk = 1'b1;
      wait_n(10);
      spi_sclk = 1'b0;
    end
    wait_n(10);
    if (nbits == 24) begin
      check(got == exp_stat, "R3 status word", 32'(got), 32'(exp_stat));
      exp_q.push_back(cmd);
    end
    spi_cs_n = 1'b1;
    wait_n(12);
    check(miso_oe == 1'b0, "R1 oe released", 32'(miso_oe), 0);
  endtask

  task automatic pulse(input int which);
    if (which == 0) seq_ovf_evt = 1'b1;
    else if (which == 1) seq_eom_evt = 1'b1;
    else seq_done = 1'b1;
    @(negedge clk);
    seq_ovf_evt = 1'b0; seq_eom_evt = 1'b0; seq_done = 1'b0;
  endtask

  // Monitor: pops expected commands as go strobes appear (R2, R4, R6).
  always @(negedge clk) begin
    if (rst_n && cmd_go) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected go: actual addr %h expected none", cmd_addr);
      end else begin
        logic [23:0] e;
        logic [23:0] a;
        e = exp_q.pop_front();
        a = {cmd_cue, cmd_record, cmd_run, cmd_use_addr, cmd_aux, cmd_addr};
        if (a != e) begin
          errors++;
          $display("FAIL R2/R6 command fields: actual %h expected %h", a, e);
        end
      end
    end
  end

  initial begin
    wait_n(2000000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check({miso_oe, irq_pull, cmd_go, op_run, cmd_addr} == 20'h0, "R1 reset state",
          32'({miso_oe, irq_pull, cmd_go, op_run, cmd_addr}), 0);

    // R2 R6 R9: record with run, address 0x1234
    frame(24'h7A_1234, 24, {2'b00, 16'hA5C3, 6'b0});
    check(op_run == 1'b1, "R9 run set", 32'(op_run), 1);
    pulse(2);
    wait_n(2);
    check(op_run == 1'b0, "R9 cleared by done", 32'(op_run), 0);

    // R5: short and long windows dropped, outputs unchanged
    frame(24'hF0_FFFF, 20, '0);
    check(cmd_addr == 16'h1234, "R5 short frame holds addr", 32'(cmd_addr), 32'h1234);
    frame(24'hF0_FFFF, 25, '0);
    check(cmd_addr == 16'h1234 && cmd_record == 1'b1, "R5 long frame holds fields",
          32'({cmd_record, cmd_addr}), 32'h11234);

    // R7: overflow event held between windows
    pulse(0);
    wait_n(1);
    check(irq_pull == 1'b1, "R7 irq set by ovf", 32'(irq_pull), 1);
    wait_n(50);
    check(irq_pull == 1'b1, "R7 irq held", 32'(irq_pull), 1);
    seq_addr = 16'h0F5A;
    frame(24'hB5_8001, 24, {2'b10, 16'h0F5A, 6'b0});
    check(op_run == 1'b1, "R9 cue run set", 32'(op_run), 1);

    // R7 R8: end-of-message event during a window is kept for the next one
    seq_addr = 16'h8000;
    fork
      frame(24'h00_0000, 24, {2'b00, 16'h8000, 6'b0});
      begin wait_n(200); pulse(1); end
    join
    check(irq_pull == 1'b1, "R7 eom raised mid-window", 32'(irq_pull), 1);
    check(op_run == 1'b0, "R9 cleared by stop command", 32'(op_run), 0);
    seq_addr = 16'h0001;
    frame(24'h4F_FFFE, 24, {2'b01, 16'h0001, 6'b0});
    check(irq_pull == 1'b0, "R8 irq stays cleared", 32'(irq_pull), 0);

    wait_n(20);
    check(exp_q.size() == 0, "R4 every full frame launched", 32'(exp_q.size()), 0);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule